// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block times an external pulse signal with a 16-bit up-counter. It can time the interval between two falling edges, the interval between two rising edges, or the high and low phases of the signal, where every edge ends one phase. On each edge that counts for the selected measurement, the block stores the counter value in a capture register. It then restarts the counter and raises a one-cycle capture strobe, which an interrupt controller can take.

The counter advances only on count ticks. One of four tick inputs is chosen: the base clock tick, a divide-by-8 tick, a divide-by-32 tick, or a slow sub-clock tick. The tick generators are outside the block. Software uses a small register port. Address 0 is the mode register, which holds the measurement select, the tick select and a read-only overflow flag. Address 1 is the read-only capture register. Counting runs only while the start input is high. The capture output is a plain strobe with no back-pressure: the capture register is overwritten at the next valid edge whether or not it was read.

Top module: `pulse_capture_timer`

## Requirements
- R1: After reset, the mode register reads 0x0000 (measurement select 00, tick select 00, overflow flag 0), the capture register reads 0x0000, and cap_irq is low.
- R2: The register port uses reg_addr 0 for the mode register and reg_addr 1 for the capture register. In the mode register, bits [1:0] are the measurement select, bits [3:2] are the tick select and bit 7 is the overflow flag; all other bits read 0. A write to address 1 has no effect.
- R3: Measurement select 00 captures on each falling edge of pulse_in, so the captured values are falling-to-falling periods.
- R4: Measurement select 01 captures on each rising edge of pulse_in, so the captured values are rising-to-rising periods.
- R5: Measurement select 10 captures on every edge, so the captured values alternate between the high time and the low time.
- R6: Measurement select 11 is reserved. No edge produces a capture, and the capture register keeps its value.
- R7: Tick select 00 counts tick_base, 01 counts tick_div8, 10 counts tick_div32 and 11 counts tick_sub.
- R8: A capture stores the number of counted ticks from the previous valid edge tick up to and including this one, modulo 2^16. The counter then restarts from zero, and cap_irq is high for one cycle.
- R9: While start is low, the counter is held at zero and no capture occurs.
- R10: A tick that takes the counter from 0xFFFF to 0x0000 without a capture sets the overflow flag, and counting continues. No register write can set the flag.
- R11: A mode register write clears the overflow flag only if start is high and the write comes on or after the first tick that follows the tick that set the flag. An earlier write leaves the flag set.
- R12: pulse_in passes through a two-flop synchronizer, and edges are detected only on ticks. A level change with no tick after it produces no capture until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Measured pulse signal, asynchronous |
| tick_base | input | 1 | Undivided base count tick |
| tick_div8 | input | 1 | Divide-by-8 count tick |
| tick_div32 | input | 1 | Divide-by-32 count tick |
| tick_sub | input | 1 | Slow sub-clock count tick |
| start | input | 1 | Counting enable |
| reg_addr | input | 1 | Register select: 0 mode, 1 capture |
| reg_wr | input | 1 | Write strobe for the mode register |
| reg_wdata | input | 4 | Write data: [1:0] measurement select, [3:2] tick select |
| reg_rdata | output | 16 | Read data for the selected register |
| cap_irq | output | 1 | One-cycle strobe on each capture |

## Verification
The bench checks the overflow clear window at its boundaries. It drives exactly 0xFFFF ticks and confirms that the flag is still clear. One more tick must set the flag. A write before the next tick must not clear it, and a write after that tick must clear it. A design that clears the flag too early, or sets it one tick late, fails one of these reads. For every measurement select, the expected values come from the edge timing the bench drives. A design that captures on the wrong polarity, captures once too often in width mode, or stores an off-by-one count shows a mismatch or an unexpected strobe. The bench also toggles the input with no tick present, runs the reserved select, and runs with start low; a design that samples edges without a tick, or captures in those states, raises a strobe where none is expected.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    MEAS_FALL = 2'b00,
    MEAS_RISE = 2'b01,
    MEAS_BOTH = 2'b10,
    MEAS_NONE = 2'b11
  } meas_e;

  typedef enum logic [1:0] {
    SRC_BASE  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_SUB   = 2'b11
  } src_e;

  localparam int unsigned FLAG_BIT = 7;
endpackage

// File: rtl/pct_tick_mux.sv
module pct_tick_mux
  import pct_pkg::*;
(
  input  src_e sel,
  input  logic tick_base,
  input  logic tick_div8,
  input  logic tick_div32,
  input  logic tick_sub,
  output logic tick
);
  logic [3:0] srcs;
  assign srcs = {tick_sub, tick_div32, tick_div8, tick_base};
  assign tick = srcs[sel];
endmodule

// File: rtl/pct_edge_sense.sv
module pct_edge_sense
  import pct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pulse_in,
  input  logic  tick,
  input  logic  start,
  input  meas_e meas,
  output logic  hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic lvl, samp_q, rise, fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pulse_in;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_in};
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  // Track the level freely while stopped; sample only on ticks while running.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              samp_q <= 1'b0;
    else if (tick || !start) samp_q <= lvl;

  assign rise = lvl & ~samp_q;
  assign fall = ~lvl & samp_q;

  always_comb begin
    hit = 1'b0;
    if (tick && start) begin
      unique case (meas)
        MEAS_FALL: hit = fall;
        MEAS_RISE: hit = rise;
        MEAS_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  // R12: between ticks while running, the sampled level stays put
  p_hold_between_ticks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tick) |=> $stable(samp_q));
endmodule

// File: rtl/pct_count_core.sv
module pct_count_core #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          hit,
  output logic [CW-1:0] cap_q,
  output logic          cap_stb,
  output logic          wrap
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      cap_stb <= 1'b0;
    end else begin
      cap_stb <= start && tick && hit;
      if (!start) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (hit) begin
          cap_q <= cnt_q + 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

  assign wrap = start && tick && !hit && (cnt_q == CNT_MAX);

  // R9: a stopped timer sits at zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt_q == '0));
  // R8: every strobe coincides with a freshly restarted counter
  p_restart_on_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (cnt_q == '0));
  // R8: the capture register changes only with a strobe
  p_cap_only_on_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |-> $stable(cap_q));
endmodule

// File: rtl/pct_ovf_flag.sv
module pct_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic tick_live,
  input  logic clr_req,
  output logic flag
);
  logic armed_q, clr_ok;

  assign clr_ok = clr_req && flag && (armed_q || tick_live);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wrap) begin
        flag    <= 1'b1;
        armed_q <= 1'b0;
      end else if (clr_ok) begin
        flag    <= 1'b0;
        armed_q <= 1'b0;
      end else if (flag && tick_live) begin
        armed_q <= 1'b1;
      end
    end

  // R11: a write before the first tick after the set leaves the flag up
  p_early_write_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed_q && !tick_live) |=> flag);
  // R10: only a wrap raises the flag
  p_no_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !wrap) |=> !flag);
  // R10: a wrap always leaves the flag set
  p_wrap_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
  import pct_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_in,
  input  logic          tick_base,
  input  logic          tick_div8,
  input  logic          tick_div32,
  input  logic          tick_sub,
  input  logic          start,
  input  logic          reg_addr,
  input  logic          reg_wr,
  input  logic [3:0]    reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          cap_irq
);
  localparam int unsigned MODE_W = FLAG_BIT + 1;

  meas_e         meas_q;
  src_e          src_q;
  logic          tick, hit, wrap, flag, mode_wr;
  logic [CW-1:0] cap_q;
  logic [MODE_W-1:0] mode_view;

  assign mode_wr = reg_wr && (reg_addr == 1'b0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meas_q <= MEAS_FALL;
      src_q  <= SRC_BASE;
    end else if (mode_wr) begin
      meas_q <= meas_e'(reg_wdata[1:0]);
      src_q  <= src_e'(reg_wdata[3:2]);
    end

  pct_tick_mux u_tick (
    .sel(src_q), .tick_base(tick_base), .tick_div8(tick_div8),
    .tick_div32(tick_div32), .tick_sub(tick_sub), .tick(tick)
  );

  pct_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .tick(tick),
    .start(start), .meas(meas_q), .hit(hit)
  );

  pct_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .hit(hit),
    .cap_q(cap_q), .cap_stb(cap_irq), .wrap(wrap)
  );

  pct_ovf_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .tick_live(tick && start),
    .clr_req(mode_wr && start), .flag(flag)
  );

  always_comb begin
    mode_view           = '0;
    mode_view[1:0]      = meas_q;
    mode_view[3:2]      = src_q;
    mode_view[FLAG_BIT] = flag;
  end

  assign reg_rdata = reg_addr ? cap_q : CW'(mode_view);

  // R6: the reserved select never yields a strobe
  p_reserved_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> ($past(meas_q) != MEAS_NONE));
  // R9: no strobe follows a cycle in which the timer was stopped
  p_stopped_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> $past(start));
endmodule

// File: tb/pulse_capture_timer_bench.sv
module pulse_capture_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b1;
  logic tick_base = 1'b1, tick_div8 = 1'b0, tick_div32 = 1'b0, tick_sub = 1'b0;
  logic start = 1'b0;
  logic reg_addr = 1'b1, reg_wr = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic cap_irq;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, irq_count = 0, div_cnt = 0;
  int exp_q[$];
  int t_last = 0, div_now = 1;
  bit have_prev = 0;
  logic lvl_prev = 1'b1;
  logic [1:0] meas_now = 2'b00;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_capture_timer u_pulse_capture_timer (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .tick_base(tick_base),
    .tick_div8(tick_div8), .tick_div32(tick_div32), .tick_sub(tick_sub),
    .start(start), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_irq(cap_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    div_cnt    <= div_cnt + 1;
    tick_div8  <= ((div_cnt + 1) % 8) == 0;
    tick_div32 <= ((div_cnt + 1) % 32) == 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pop the expected item for every strobe and compare.
  always @(negedge clk) begin
    if (rst_n && cap_irq) begin
      int v;
      irq_count++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected capture", reg_rdata, -1);
      end else begin
        v = exp_q.pop_front();
        if (v >= 0) check(reg_rdata == v[15:0], "R8 capture value", reg_rdata, v);
      end
    end
  end

  task automatic wr_mode(input logic [3:0] d);
    @(negedge clk); reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b1;
    meas_now = d[1:0];
  endtask

  task automatic wr_cap(input logic [3:0] d);
    @(negedge clk); reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    reg_addr = 1'b1;
  endtask

  // Driver: wait, drive a level, push the expected capture when the edge counts.
  task automatic step(input logic v, input int gap);
    bit valid;
    repeat (gap) @(negedge clk);
    pulse_in = v;
    case (meas_now)
      2'b00: valid = lvl_prev && !v;
      2'b01: valid = !lvl_prev && v;
      2'b10: valid = lvl_prev != v;
      default: valid = 0;
    endcase
    if (valid) begin
      if (have_prev) exp_q.push_back((cyc - t_last) / div_now);
      else           exp_q.push_back(-1);
      t_last = cyc; have_prev = 1;
    end
    lvl_prev = v;
  endtask

  task automatic begin_seg(input logic [3:0] mode, input int div);
    wr_mode(mode); div_now = div; have_prev = 0;
    @(negedge clk); start = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_seg(input string req);
    repeat (12 * div_now) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    start = 1'b0; exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, held;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, d); check(d == 16'h0000, "R1 mode reset", d, 0);
    rd(1'b1, d); check(d == 16'h0000, "R1 capture reset", d, 0);
    check(cap_irq == 1'b0, "R1 irq reset", cap_irq, 0);

    // R2: field placement and read-back
    wr_mode(4'b1110); rd(1'b0, d);
    check(d == 16'h000E, "R2 mode readback", d, 16'h000E);
    wr_mode(4'b0000);

    // R3: falling-to-falling periods
    begin_seg(4'b0000, 1);
    step(0, 2); step(1, 6); step(0, 5); step(1, 9); step(0, 4); step(1, 7); step(0, 13);
    end_seg("R3 all falling captures seen");

    // R4: rising-to-rising periods
    begin_seg(4'b0001, 1);
    step(0, 2); step(1, 5); step(0, 8); step(1, 6); step(0, 4); step(1, 11);
    end_seg("R4 all rising captures seen");

    // R5: width on every edge
    begin_seg(4'b0010, 1);
    step(0, 2); step(1, 7); step(0, 4); step(1, 10); step(0, 5);
    end_seg("R5 all width captures seen");

    // R7: divide-by-8 source, gaps in multiples of 8
    begin_seg(4'b0110, 8);
    step(0, 8); step(1, 24); step(0, 40); step(1, 16);
    end_seg("R7 div8 captures seen");

    // R7: divide-by-32 source
    begin_seg(4'b1010, 32);
    step(0, 32); step(1, 64); step(0, 96);
    end_seg("R7 div32 captures seen");

    // R2: write to the capture address is ignored
    rd(1'b1, held); wr_cap(4'b0101); rd(1'b1, d);
    check(d == held, "R2 capture write ignored", d, held);

    // R6: reserved select, no strobes, capture unchanged
    base = irq_count;
    begin_seg(4'b0011, 1);
    step(0, 3); step(1, 5); step(0, 5); step(1, 5);
    repeat (10) @(negedge clk);
    check(irq_count == base, "R6 no strobe", irq_count, base);
    start = 1'b0; repeat (2) @(negedge clk);
    rd(1'b1, d); check(d == held, "R6 capture kept", d, held);

    // R9: stopped timer ignores edges
    wr_mode(4'b0010); base = irq_count;
    step(0, 3); step(1, 5); step(0, 5);
    repeat (10) @(negedge clk);
    check(irq_count == base, "R9 no strobe while stopped", irq_count, base);

    // R12: no tick, no edge seen; first tick after toggle captures
    wr_mode(4'b1110); tick_base = 1'b0;
    @(negedge clk); start = 1'b1; repeat (3) @(negedge clk);
    base = irq_count;
    pulse_in = 1'b1; repeat (10) @(negedge clk);
    check(irq_count == base, "R12 no tick no capture", irq_count, base);
    exp_q.push_back(-1);
    tick_sub = 1'b1; @(negedge clk); tick_sub = 1'b0;
    repeat (4) @(negedge clk);
    check(irq_count == base + 1, "R12 capture on tick", irq_count, base + 1);
    start = 1'b0; repeat (2) @(negedge clk);

    // R10/R11: overflow flag window, pulse held constant
    wr_mode(4'b1100);
    rd(1'b0, d); check(d[7] == 1'b0, "R10 flag not set by write", d[7], 0);
    @(negedge clk); start = 1'b1; tick_sub = 1'b1;
    repeat (65535) @(negedge clk);
    tick_sub = 1'b0;
    rd(1'b0, d); check(d[7] == 1'b0, "R10 no flag at 0xFFFF", d[7], 0);
    @(negedge clk); tick_sub = 1'b1; @(negedge clk); tick_sub = 1'b0;
    rd(1'b0, d); check(d[7] == 1'b1, "R10 flag on wrap", d[7], 1);
    wr_mode(4'b1100);
    rd(1'b0, d); check(d[7] == 1'b1, "R11 early write keeps flag", d[7], 1);
    @(negedge clk); tick_sub = 1'b1; @(negedge clk); tick_sub = 1'b0;
    rd(1'b0, d); check(d[7] == 1'b1, "R11 tick alone keeps flag", d[7], 1);
    wr_mode(4'b1100);
    rd(1'b0, d); check(d[7] == 1'b0, "R11 later write clears flag", d[7], 0);
    start = 1'b0;

    repeat (5) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule